// File: doc/BRIEF.md
# Asynchronous External Memory Bridge

The bridge is a slave on a simplified AHB-Lite bus. It maps a 128 MB window of the system address space onto asynchronous parallel memories such as SRAM or NOR flash. It accepts one single transfer at a time. Each byte, half-word or word request is split into a sequence of narrow external cycles on an 8-bit or 16-bit data bus. HREADY is held low for as many wait states as the sequence takes. Read bytes are gathered little-endian into HRDATA. Write bytes are taken from HWDATA, which the master holds stable through the wait states. Each write byte goes out under its own active-low lane write strobe.

The window is split in two halves, and each half has its own active-low chip select. The bus width and a 4-bit extra-wait count come in as static configuration inputs. Both are sampled when a transfer is accepted. Misaligned requests are handled by walking the byte addresses the request covers, and such a request may cross a word boundary.

The controller has six states:
- IDLE: no transfer in progress.
- SETUP: one external cycle of address and chip select.
- FETCH: read data settling, 2 + wait cycles.
- STROBE: write strobe low, 1 + wait cycles.
- HOLD: one cycle with the strobe released and the address still held.
- DONE: the data phase completes with HREADY high.

The transitions are:
- IDLE→SETUP and DONE→SETUP on an accepted in-window transfer.
- IDLE→IDLE and DONE→IDLE when no transfer is accepted.
- SETUP→FETCH on a read, and SETUP→STROBE on a write.
- FETCH→SETUP or STROBE→HOLD→SETUP when more external cycles remain.
- FETCH→DONE and HOLD→DONE after the last external cycle.

Top module: `extmem_bridge`

## Requirements
- R1: A transfer outside 0x7000_0000..0x77FF_FFFF, or with HSEL low or HTRANS[1] low, completes with zero wait states and drives no chip select.
- R2: mem_cs_n[0] is active (low) for offsets with address bit 26 = 0 (0x7000_0000..0x73FF_FFFF). mem_cs_n[1] is active for bit 26 = 1 (0x7400_0000..0x77FF_FFFF). At most one chip select is low at any time.
- R3: With cfg_bus16 = 0 there is one external cycle per byte, and mem_addr is the byte offset within the region. With cfg_bus16 = 1 there is one external cycle per half-word, mem_addr bit 0 is 0, and data lane 0 (bits 7:0) carries the even byte.
- R4: A request covers the bytes A..A+2^HSIZE-1 (HSIZE 0, 1 or 2), and misaligned and word-crossing requests are allowed. The byte at address b travels on HRDATA/HWDATA lane b[1:0], bits 8*b[1:0]+7 downto 8*b[1:0].
- R5: A read shows beats × (3 + cfg_wait) wait states, where beats is the number of external cycles from R3.
- R6: A write shows beats × (3 + cfg_wait) wait states, and in each of its external cycles the strobe is low for 1 + cfg_wait cycles.
- R7: A lane write strobe goes low only after address and chip select have been unchanged for one cycle, and address and chip select stay unchanged for one cycle after it rises.
- R8: Only lanes holding requested bytes are strobed, so a write strobes n × (1 + cfg_wait) lane-cycles in total. With cfg_bus16 = 0, mem_wen_n[1] never goes low.
- R9: In the completing cycle of a read, lanes for bytes that were not requested read 0. HRESP is always 0 (OKAY).
- R10: mem_dq_oe is high only during write cycles. It is never high while mem_oe_n is low, nor in the cycle after mem_oe_n was low. mem_oe_n is low only during read cycles.
- R11: After reset, HREADY is 1, both chip selects, mem_oe_n and both strobes are 1, and mem_dq_oe is 0.
- R12: A transfer presented in the completing (DONE) cycle of the previous one is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Transfer address |
| htrans | input | 2 | Transfer type; bit 1 marks an active transfer |
| hwrite | input | 1 | 1 = write |
| hsize | input | 3 | Size: 0 byte, 1 half-word, 2 word |
| hwdata | input | 32 | Write data, held during wait states |
| hrdata | output | 32 | Read data, valid in the completing cycle |
| hready | output | 1 | Low while the data phase is stalled |
| hresp | output | 1 | Response, always OKAY (0) |
| cfg_bus16 | input | 1 | 0 = 8-bit external bus, 1 = 16-bit |
| cfg_wait | input | 4 | Extra wait cycles for fetch and strobe phases |
| mem_addr | output | 26 | External byte offset within a chip-select region |
| mem_cs_n | output | 2 | Active-low chip selects, one per window half |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_wen_n | output | 2 | Active-low per-lane write strobes |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out; 0 = bus released |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
Two things can fall in the same cycle. One is the completion of a transfer, in the DONE state with HRDATA valid. The other is the acceptance of the next one, whose configuration and address are latched in that same cycle. The vector table provokes this by presenting every transfer in the cycle where the previous one completes, including read-then-write and write-then-read pairs across both bus widths. The outcome is judged in three ways: by the wait-state count and read-back data of each transfer against a byte-level shadow of memory, by a directed test that measures the gap between two completions, and by monitors that watch bus turnaround and strobe setup/hold across those boundaries.

// File: rtl/extmem_pkg.sv
package extmem_pkg;

    localparam int EXT_ADDR_W   = 32;
    localparam int EXT_OFS_W    = 27;
    localparam int EXT_WAIT_W   = 4;
    localparam int EXT_DATA_W   = 32;
    localparam int EXT_MEM_DW   = 16;
    localparam logic [4:0] EXT_WIN_TAG = 5'b01110;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_FETCH,
        S_STROBE,
        S_HOLD,
        S_DONE
    } xfer_state_e;

endpackage

// File: rtl/extmem_decode.sv
module extmem_decode #(
    parameter int ADDR_W = extmem_pkg::EXT_ADDR_W,
    parameter int OFS_W  = extmem_pkg::EXT_OFS_W,
    parameter logic [ADDR_W-OFS_W-1:0] WIN_TAG = extmem_pkg::EXT_WIN_TAG
) (
    input  logic              hsel,
    input  logic [1:0]        htrans,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [2:0]        hsize,
    output logic              hit,
    output logic [OFS_W-1:0]  first_ofs,
    output logic [OFS_W-1:0]  last_ofs
);

    logic [2:0] span_m1;

    always_comb begin
        unique case (hsize)
            3'd0:    span_m1 = 3'd0;
            3'd1:    span_m1 = 3'd1;
            default: span_m1 = 3'd3;
        endcase
    end

    assign hit       = hsel && htrans[1] && (haddr[ADDR_W-1:OFS_W] == WIN_TAG);
    assign first_ofs = haddr[OFS_W-1:0];
    assign last_ofs  = haddr[OFS_W-1:0] + OFS_W'(span_m1);

endmodule

// File: rtl/extmem_beat.sv
module extmem_beat #(
    parameter int OFS_W  = extmem_pkg::EXT_OFS_W,
    parameter int MEM_DW = extmem_pkg::EXT_MEM_DW,
    localparam int LANES = MEM_DW / 8
) (
    input  logic [OFS_W-1:0] cur,
    input  logic [OFS_W-1:0] first_ofs,
    input  logic [OFS_W-1:0] last_ofs,
    input  logic             wide,
    output logic [OFS_W-1:0] base,
    output logic [OFS_W-1:0] nxt,
    output logic [LANES-1:0] lane_ok,
    output logic             last
);

    logic [OFS_W-1:0] top_byte;

    always_comb begin
        if (wide) begin
            base     = {cur[OFS_W-1:1], 1'b0};
            top_byte = {cur[OFS_W-1:1], 1'b1};
            for (int i = 0; i < LANES; i++) begin
                lane_ok[i] = ((base + OFS_W'(i)) >= first_ofs) &&
                             ((base + OFS_W'(i)) <= last_ofs);
            end
        end else begin
            base     = cur;
            top_byte = cur;
            lane_ok  = LANES'(1);
        end
        last = (top_byte >= last_ofs);
        nxt  = top_byte + OFS_W'(1);
    end

    always_comb begin
        // R4
        lane_cover_chk: assert (!wide || !last || lane_ok != '0 || cur < first_ofs)
            else $error("final beat enables no lane");
    end

endmodule

// File: rtl/extmem_ctrl.sv
module extmem_ctrl
    import extmem_pkg::*;
#(
    parameter int OFS_W  = EXT_OFS_W,
    parameter int WAIT_W = EXT_WAIT_W,
    parameter int DATA_W = EXT_DATA_W,
    parameter int MEM_DW = EXT_MEM_DW,
    localparam int LANES  = MEM_DW / 8,
    localparam int BYTES  = DATA_W / 8,
    localparam int LSEL_W = $clog2(BYTES),
    localparam int MA_W   = OFS_W - 1,
    localparam int CNT_W  = WAIT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              hwrite,
    input  logic [OFS_W-1:0]  first_i,
    input  logic [OFS_W-1:0]  last_i,
    input  logic              cfg_bus16,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [DATA_W-1:0] hwdata,
    input  logic [OFS_W-1:0]  base_i,
    input  logic [OFS_W-1:0]  nxt_i,
    input  logic [LANES-1:0]  lane_ok_i,
    input  logic              beat_last_i,
    output logic [OFS_W-1:0]  cur_o,
    output logic [OFS_W-1:0]  first_o,
    output logic [OFS_W-1:0]  last_o,
    output logic              wide_o,
    output logic              hready,
    output logic [DATA_W-1:0] hrdata,
    output logic [MA_W-1:0]   mem_addr,
    output logic [1:0]        mem_cs_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_wen_n,
    output logic [MEM_DW-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [MEM_DW-1:0] mem_dq_in
);

    xfer_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [OFS_W-1:0]  cur_q, first_q, last_q;
    logic              write_q, wide_q;
    logic [WAIT_W-1:0] wait_q;
    logic [DATA_W-1:0] rdata_q;
    logic              busy, take;
    logic [LSEL_W-1:0] lane_idx [LANES];
    logic [7:0]        wr_byte  [LANES];

    assign cur_o   = cur_q;
    assign first_o = first_q;
    assign last_o  = last_q;
    assign wide_o  = wide_q;

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign take = (state_q == S_IDLE || state_q == S_DONE) && acc;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_DONE: state_d = acc ? S_SETUP : S_IDLE;
            S_SETUP:        state_d = write_q ? S_STROBE : S_FETCH;
            S_FETCH: begin
                if (cnt_q == '0) begin
                    state_d = beat_last_i ? S_DONE : S_SETUP;
                end
            end
            S_STROBE: begin
                if (cnt_q == '0) begin
                    state_d = S_HOLD;
                end
            end
            S_HOLD:         state_d = beat_last_i ? S_DONE : S_SETUP;
            default:        state_d = S_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // Transfer context, phase counter and read assembly
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cur_q   <= '0;
            first_q <= '0;
            last_q  <= '0;
            write_q <= 1'b0;
            wide_q  <= 1'b0;
            wait_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (take) begin
                cur_q   <= first_i;
                first_q <= first_i;
                last_q  <= last_i;
                write_q <= hwrite;
                wide_q  <= cfg_bus16;
                wait_q  <= cfg_wait;
                rdata_q <= '0;
            end
            unique case (state_q)
                S_SETUP: begin
                    cnt_q <= write_q ? {1'b0, wait_q} : ({1'b0, wait_q} + CNT_W'(1));
                end
                S_FETCH: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end else begin
                        for (int i = 0; i < LANES; i++) begin
                            if (lane_ok_i[i]) begin
                                rdata_q[8*lane_idx[i] +: 8] <= mem_dq_in[8*i +: 8];
                            end
                        end
                        if (!beat_last_i) begin
                            cur_q <= nxt_i;
                        end
                    end
                end
                S_STROBE: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                S_HOLD: begin
                    if (!beat_last_i) begin
                        cur_q <= nxt_i;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Lane steering between the wide bus and the narrow bus
    // ---------------------------------------------------------------
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_idx[g] = wide_q ? (base_i[LSEL_W-1:0] | LSEL_W'(g)) : cur_q[LSEL_W-1:0];
        assign wr_byte[g]  = hwdata[8*lane_idx[g] +: 8];
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_comb begin
        busy       = (state_q == S_SETUP) || (state_q == S_FETCH) ||
                     (state_q == S_STROBE) || (state_q == S_HOLD);
        hready     = !busy;
        hrdata     = rdata_q;
        mem_addr   = base_i[MA_W-1:0];
        mem_cs_n   = 2'b11;
        if (busy) begin
            mem_cs_n[base_i[OFS_W-1]] = 1'b0;
        end
        mem_oe_n   = !(busy && !write_q);
        mem_dq_oe  = busy && write_q;
        mem_wen_n  = '1;
        if (state_q == S_STROBE) begin
            mem_wen_n = wide_q ? ~lane_ok_i : {{(LANES-1){1'b1}}, 1'b0};
        end
        mem_dq_out = '0;
        if (wide_q) begin
            for (int i = 0; i < LANES; i++) begin
                mem_dq_out[8*i +: 8] = wr_byte[i];
            end
        end else begin
            mem_dq_out[7:0] = wr_byte[0];
        end
    end

    // ---------------------------------------------------------------
    // Checks on the external interface
    // ---------------------------------------------------------------
    // R2
    cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    // R7
    we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen_n != '1) |-> ($past(mem_cs_n) == mem_cs_n && $past(mem_addr) == mem_addr));

    // R7
    we_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen_n != '1) |=> ($stable(mem_addr) && $stable(mem_cs_n)));

    // R10
    no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R10
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |=> !mem_dq_oe);

    // R8
    strobe_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen_n != '1) |-> (mem_dq_oe && mem_cs_n != 2'b11));

endmodule

// File: rtl/extmem_bridge.sv
module extmem_bridge
    import extmem_pkg::*;
#(
    parameter int ADDR_W = EXT_ADDR_W,
    parameter int OFS_W  = EXT_OFS_W,
    parameter int WAIT_W = EXT_WAIT_W,
    parameter int DATA_W = EXT_DATA_W,
    parameter int MEM_DW = EXT_MEM_DW,
    parameter logic [ADDR_W-OFS_W-1:0] WIN_TAG = EXT_WIN_TAG,
    localparam int LANES = MEM_DW / 8,
    localparam int MA_W  = OFS_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [DATA_W-1:0] hwdata,
    output logic [DATA_W-1:0] hrdata,
    output logic              hready,
    output logic              hresp,
    input  logic              cfg_bus16,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic [MA_W-1:0]   mem_addr,
    output logic [1:0]        mem_cs_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_wen_n,
    output logic [MEM_DW-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [MEM_DW-1:0] mem_dq_in
);

    logic             hit;
    logic [OFS_W-1:0] req_first, req_last;
    logic [OFS_W-1:0] cur, ctx_first, ctx_last, base, nxt;
    logic [LANES-1:0] lane_ok;
    logic             beat_last, wide;

    assign hresp = 1'b0;

    extmem_decode #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W),
        .WIN_TAG(WIN_TAG)
    ) u_decode (
        .hsel     (hsel),
        .htrans   (htrans),
        .haddr    (haddr),
        .hsize    (hsize),
        .hit      (hit),
        .first_ofs(req_first),
        .last_ofs (req_last)
    );

    extmem_beat #(
        .OFS_W (OFS_W),
        .MEM_DW(MEM_DW)
    ) u_beat (
        .cur      (cur),
        .first_ofs(ctx_first),
        .last_ofs (ctx_last),
        .wide     (wide),
        .base     (base),
        .nxt      (nxt),
        .lane_ok  (lane_ok),
        .last     (beat_last)
    );

    extmem_ctrl #(
        .OFS_W (OFS_W),
        .WAIT_W(WAIT_W),
        .DATA_W(DATA_W),
        .MEM_DW(MEM_DW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (hit),
        .hwrite     (hwrite),
        .first_i    (req_first),
        .last_i     (req_last),
        .cfg_bus16  (cfg_bus16),
        .cfg_wait   (cfg_wait),
        .hwdata     (hwdata),
        .base_i     (base),
        .nxt_i      (nxt),
        .lane_ok_i  (lane_ok),
        .beat_last_i(beat_last),
        .cur_o      (cur),
        .first_o    (ctx_first),
        .last_o     (ctx_last),
        .wide_o     (wide),
        .hready     (hready),
        .hrdata     (hrdata),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_oe_n   (mem_oe_n),
        .mem_wen_n  (mem_wen_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    // R1
    out_window_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && !hit) |=> (hready && mem_cs_n == 2'b11));

endmodule

// File: tb/extmem_bridge_tb_top.sv
module extmem_bridge_tb_top;

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [31:0] wd;
        logic        b16;
        logic [3:0]  wt;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 2'd2, 32'h7000_0000, 32'h4433_2211, 1'b0, 4'd0},
        '{1'b0, 2'd2, 32'h7000_0000, 32'h0,         1'b0, 4'd0},
        '{1'b0, 2'd2, 32'h7000_0000, 32'h0,         1'b1, 4'd2},
        '{1'b1, 2'd1, 32'h7000_0006, 32'hBEEF_0000, 1'b1, 4'd1},
        '{1'b0, 2'd0, 32'h7000_0007, 32'h0,         1'b1, 4'd0},
        '{1'b1, 2'd2, 32'h7000_0011, 32'hA1B2_C3D4, 1'b1, 4'd0},
        '{1'b0, 2'd2, 32'h7000_0011, 32'h0,         1'b0, 4'd3},
        '{1'b1, 2'd1, 32'h7400_0020, 32'h0000_5A6B, 1'b0, 4'd0},
        '{1'b0, 2'd1, 32'h7400_0020, 32'h0,         1'b1, 4'd5},
        '{1'b1, 2'd0, 32'h7400_0031, 32'h0000_7700, 1'b1, 4'd0},
        '{1'b0, 2'd2, 32'h7400_0030, 32'h0,         1'b1, 4'd0},
        '{1'b0, 2'd1, 32'h7000_0003, 32'h0,         1'b0, 4'd1},
        '{1'b1, 2'd0, 32'h7000_0005, 32'h0000_AB00, 1'b0, 4'd0},
        '{1'b0, 2'd2, 32'h7000_0004, 32'h0,         1'b1, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'd0;
    logic [31:0] hwdata = '0;
    logic [31:0] hrdata;
    logic        hready, hresp;
    logic        cfg_bus16 = 1'b0;
    logic [3:0]  cfg_wait = 4'd0;
    logic [25:0] mem_addr;
    logic [1:0]  mem_cs_n;
    logic        mem_oe_n;
    logic [1:0]  mem_wen_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mem    [512];
    logic [7:0] shadow [512];

    // monitors
    logic [1:0]  cs_seen = '0;
    int          strobe_cycles = 0;
    int          lane_cycles = 0;
    bit          cur_b16 = 1'b0;
    int          we_viol = 0, turn_viol = 0, lane_viol = 0, addr_viol = 0, resp_viol = 0, cs_viol = 0;
    logic [1:0]  prev_cs = 2'b11;
    logic [25:0] prev_addr = '0;
    logic [1:0]  prev_wen = 2'b11;
    logic        prev_oe = 1'b1;
    int          cyc = 0;
    int          last_done = 0;

    extmem_bridge dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsel      (hsel),
        .haddr     (haddr),
        .htrans    (htrans),
        .hwrite    (hwrite),
        .hsize     (hsize),
        .hwdata    (hwdata),
        .hrdata    (hrdata),
        .hready    (hready),
        .hresp     (hresp),
        .cfg_bus16 (cfg_bus16),
        .cfg_wait  (cfg_wait),
        .mem_addr  (mem_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_oe_n  (mem_oe_n),
        .mem_wen_n (mem_wen_n),
        .mem_dq_out(mem_dq_out),
        .mem_dq_oe (mem_dq_oe),
        .mem_dq_in (mem_dq_in)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // asynchronous memory model, byte array indexed {region, offset[7:0]}
    logic msel;
    assign msel = ~mem_cs_n[1];
    always_comb begin
        mem_dq_in = 16'h0000;
        if (!mem_oe_n && mem_cs_n != 2'b11) begin
            mem_dq_in[7:0] = mem[{msel, mem_addr[7:0]}];
            if (cfg_bus16 || cur_b16) begin
                mem_dq_in[15:8] = mem[{msel, mem_addr[7:0] + 8'd1}];
            end
        end
    end

    always @(posedge clk) begin
        if (mem_cs_n != 2'b11) begin
            if (!mem_wen_n[0]) mem[{msel, mem_addr[7:0]}] <= mem_dq_out[7:0];
            if (!mem_wen_n[1]) mem[{msel, mem_addr[7:0] + 8'd1}] <= mem_dq_out[15:8];
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            cs_seen <= cs_seen | ~mem_cs_n;
            if (mem_cs_n == 2'b00) cs_viol++;
            if (mem_wen_n != 2'b11) strobe_cycles++;
            lane_cycles += $countones(~mem_wen_n);
            if (mem_wen_n != 2'b11 && (prev_cs != mem_cs_n || prev_addr != mem_addr)) we_viol++;
            if (prev_wen != 2'b11 && (prev_cs != mem_cs_n || prev_addr != mem_addr)) we_viol++;
            if (mem_dq_oe && (!prev_oe || !mem_oe_n)) turn_viol++;
            if (!cur_b16 && !mem_wen_n[1]) lane_viol++;
            if (cur_b16 && mem_cs_n != 2'b11 && mem_addr[0]) addr_viol++;
            if (hresp) resp_viol++;
            prev_cs   <= mem_cs_n;
            prev_addr <= mem_addr;
            prev_wen  <= mem_wen_n;
            prev_oe   <= mem_oe_n;
        end
    end

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [8:0] sidx(input logic [26:0] b);
        return {b[26], b[7:0]};
    endfunction

    // one transfer; entered and left at a negedge with hready high
    task automatic xfer(input logic wr, input logic [1:0] sz, input logic [31:0] addr,
                        input logic [31:0] wd, input logic b16, input logic [3:0] wt,
                        input bit in_win);
        int n, beats, waits, exp_waits;
        logic [26:0] ofs, b;
        logic [31:0] exp_rd;
        n   = 1 << sz;
        ofs = addr[26:0];
        beats = b16 ? int'(((ofs + 27'(n - 1)) >> 1) - (ofs >> 1)) + 1 : n;
        exp_waits = in_win ? beats * (3 + int'(wt)) : 0;
        exp_rd = '0;
        for (int k = 0; k < n; k++) begin
            b = ofs + 27'(k);
            exp_rd[8*b[1:0] +: 8] = shadow[sidx(b)];
        end
        hsel = 1'b1; haddr = addr; htrans = 2'b10; hwrite = wr; hsize = {1'b0, sz};
        cfg_bus16 = b16; cfg_wait = wt;
        @(posedge clk);
        #1;
        cs_seen = '0; strobe_cycles = 0; lane_cycles = 0; cur_b16 = b16;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwdata = wd;
        waits = 0;
        while (!hready && waits < 2000) begin
            waits++;
            @(negedge clk);
        end
        last_done = cyc;
        if (!in_win) begin
            check(waits == 0, "R1 out-of-window wait states", waits, 0);
            check(cs_seen == 2'b00, "R1 out-of-window chip select", cs_seen, 0);
        end else begin
            check(cs_seen == (2'b01 << ofs[26]), "R2 chip select region", cs_seen, 2'b01 << ofs[26]);
            if (wr) begin
                check(waits == exp_waits, "R6 write wait states", waits, exp_waits);
                check(strobe_cycles == beats * (1 + int'(wt)), "R6 strobe length",
                      strobe_cycles, beats * (1 + int'(wt)));
                check(lane_cycles == n * (1 + int'(wt)), "R8 lane strobes",
                      lane_cycles, n * (1 + int'(wt)));
                for (int k = 0; k < n; k++) begin
                    b = ofs + 27'(k);
                    shadow[sidx(b)] = wd[8*b[1:0] +: 8];
                end
            end else begin
                check(waits == exp_waits, "R5 read wait states", waits, exp_waits);
                check(hrdata == exp_rd, "R4/R9 read data lanes", hrdata, exp_rd);
            end
        end
    endtask

    initial begin
        int t0;
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'h00;
            shadow[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R11 reset state
        check(hready == 1'b1, "R11 hready", hready, 1);
        check(mem_cs_n == 2'b11, "R11 chip selects", mem_cs_n, 2'b11);
        check(mem_oe_n == 1'b1, "R11 output enable", mem_oe_n, 1);
        check(mem_wen_n == 2'b11, "R11 strobes", mem_wen_n, 2'b11);
        check(mem_dq_oe == 1'b0, "R11 data drive", mem_dq_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: every entry presented in the previous one's DONE cycle (R12)
        for (int v = 0; v < NVEC; v++) begin
            xfer(VECS[v].wr, VECS[v].sz, VECS[v].addr, VECS[v].wd, VECS[v].b16, VECS[v].wt, 1'b1);
        end

        // R1 transfers outside the window
        xfer(1'b1, 2'd2, 32'h7800_0000, 32'hFFFF_FFFF, 1'b0, 4'd0, 1'b0);
        xfer(1'b0, 2'd2, 32'h6FFF_FFFC, 32'h0, 1'b1, 4'd0, 1'b0);
        // R1 inactive transfer type inside the window
        hsel = 1'b1; haddr = 32'h7000_0000; htrans = 2'b00;
        @(posedge clk); #1; cs_seen = '0;
        @(negedge clk); hsel = 1'b0;
        check(hready == 1'b1 && cs_seen == 2'b00, "R1 idle transfer ignored", {hready, cs_seen}, 3'b100);
        xfer(1'b0, 2'd2, 32'h7000_0000, 32'h0, 1'b0, 4'd0, 1'b1);

        // R5 longest wait setting on an 8-bit word
        xfer(1'b0, 2'd2, 32'h7000_0010, 32'h0, 1'b0, 4'd15, 1'b1);

        // R12 completion-to-completion gap for back-to-back transfers
        xfer(1'b0, 2'd0, 32'h7400_0021, 32'h0, 1'b0, 4'd0, 1'b1);
        t0 = last_done;
        xfer(1'b1, 2'd1, 32'h7400_0040, 32'h0000_1234, 1'b1, 4'd2, 1'b1);
        check(last_done - t0 == 1 + 5, "R12 back-to-back acceptance", last_done - t0, 6);
        xfer(1'b0, 2'd1, 32'h7400_0040, 32'h0, 1'b0, 4'd0, 1'b1);

        @(negedge clk);
        check(we_viol == 0, "R7 strobe setup/hold", we_viol, 0);
        check(turn_viol == 0, "R10 bus turnaround", turn_viol, 0);
        check(lane_viol == 0, "R8 upper strobe in 8-bit mode", lane_viol, 0);
        check(addr_viol == 0, "R3 half-word address alignment", addr_viol, 0);
        check(resp_viol == 0, "R9 response OKAY", resp_viol, 0);
        check(cs_viol == 0, "R2 single chip select", cs_viol, 0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule